// File: doc/BRIEF.md
# Eight-bit arithmetic and logic unit with status flags

This block is the combinational execution unit of a small accumulator-style processor core. Each evaluation takes two byte operands, a five-bit operation code and the current carry and digit-carry bits. It returns a byte result and a double-width product. For each of the four status flags (carry C, digit carry DC, zero Z, overflow OV) it also returns a next value and a write enable. The surrounding core owns the status register. It latches a flag only when that flag's enable is high, so every operation updates only the flags that belong to it.

All additive operations share one adder: add, add with carry, subtract, subtract with borrow, increment, decrement and negate. Subtraction is formed by adding the inverted subtrahend with a carry-in. The carry out of the whole word and the carry out of the low nibble therefore mean "no borrow". A separate unit handles the bitwise operations, the nibble swap and the four rotates. A multiplier produces the unsigned product. Register access, destination selection and decimal adjust belong to the surrounding core.

Top module: `alu_core`

## Requirements
- R1: Code 0 (add) gives a+b and code 1 (add with carry) gives a+b+c_i. Both write all four flags. C is the carry out of bit 7, DC is the carry out of bit 3, OV is set on two's-complement overflow, and Z is set when the byte result is zero.
- R2: Code 2 (subtract) gives a-b and code 3 (subtract with borrow) gives a-b-(1-c_i). Both write all four flags. C is 1 when no borrow leaves bit 7, so for code 2 C = (a >= b) unsigned. DC is 1 when no borrow leaves the low nibble. OV marks signed overflow and Z marks a zero result.
- R3: Code 4 (increment) gives a+1 and code 5 (decrement) gives a-1. Their C, DC, OV and Z follow R1 and R2 with the constant 1 as the second operand, and all four flags are written.
- R4: Codes 6, 7, 8 and 9 give a AND b, a OR b, a XOR b and NOT a. Each writes only Z.
- R5: Code 10 (negate) gives 0-a. It writes C, OV and Z but not DC. C follows the no-borrow rule, so C is 1 only when a is 0, and OV is set only when a is 0x80.
- R6: Code 12 rotates left through carry: the result is {a[6:0], c_i} and C becomes a[7]. Code 13 rotates right through carry: the result is {c_i, a[7:1]} and C becomes a[0]. Both write only C.
- R7: Code 14 rotates left and code 15 rotates right, with the outgoing bit wrapping to the other end. Neither writes any flag.
- R8: Code 11 exchanges a[7:4] with a[3:0] and writes no flag.
- R9: Code 16 drives the full unsigned product a*b on prod_o and its low byte on res_o, and writes no flag.
- R10: When a flag enable is low, c_o equals c_i and dc_o equals dc_i, while z_o and ov_o are 0.
- R11: Codes 17 to 31 are unassigned. They give a zero result, a zero product and no flag enables.
- R12: prod_o is zero for every code other than 16.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_i | input | 5 | Operation code |
| a_i | input | DATA_W | First operand (the operand of single-operand codes) |
| b_i | input | DATA_W | Second operand |
| c_i | input | 1 | Current carry flag |
| dc_i | input | 1 | Current digit-carry flag |
| res_o | output | DATA_W | Byte result |
| prod_o | output | 2*DATA_W | Multiply product, zero for other codes |
| c_o | output | 1 | Next carry value |
| dc_o | output | 1 | Next digit-carry value |
| z_o | output | 1 | Next zero value |
| ov_o | output | 1 | Next overflow value |
| c_we_o | output | 1 | Carry write enable |
| dc_we_o | output | 1 | Digit-carry write enable |
| z_we_o | output | 1 | Zero write enable |
| ov_we_o | output | 1 | Overflow write enable |

## Verification
The embedded checks are immediate and evaluate whenever the inputs change. They assume that op_i, the operands and both incoming flags are two-state values that are stable for the whole evaluation, and that an unassigned code is a legal input rather than an error. The bench keeps within this by driving every input together on the falling clock edge and comparing one time unit later. It draws op_i from the full five-bit range so that the unassigned codes are exercised alongside the defined ones.

// File: rtl/alu_pkg.sv
package alu_pkg;

    localparam int OP_W = 5;

    typedef enum logic [OP_W-1:0] {
        OP_ADD  = 5'd0,
        OP_ADDC = 5'd1,
        OP_SUB  = 5'd2,
        OP_SUBB = 5'd3,
        OP_INC  = 5'd4,
        OP_DEC  = 5'd5,
        OP_AND  = 5'd6,
        OP_OR   = 5'd7,
        OP_XOR  = 5'd8,
        OP_COM  = 5'd9,
        OP_NEG  = 5'd10,
        OP_SWAP = 5'd11,
        OP_RLC  = 5'd12,
        OP_RRC  = 5'd13,
        OP_RL   = 5'd14,
        OP_RR   = 5'd15,
        OP_MUL  = 5'd16
    } alu_op_e;

    // Which status bits an operation is allowed to touch
    typedef struct packed {
        logic c;
        logic dc;
        logic z;
        logic ov;
    } flag_set_t;

    // Operand steering for the shared adder
    typedef enum logic [0:0] {X_OPA, X_ZERO} x_sel_e;
    typedef enum logic [2:0] {Y_OPB, Y_NOT_B, Y_ZERO, Y_ONES, Y_NOT_A} y_sel_e;
    typedef enum logic [1:0] {CI_ZERO, CI_ONE, CI_FLAG} ci_sel_e;

    typedef struct packed {
        x_sel_e  xs;
        y_sel_e  ys;
        ci_sel_e cs;
    } arith_ctl_t;

    function automatic logic is_arith(alu_op_e op);
        case (op)
            OP_ADD, OP_ADDC, OP_SUB, OP_SUBB,
            OP_INC, OP_DEC, OP_NEG: return 1'b1;
            default:                return 1'b0;
        endcase
    endfunction

    function automatic logic is_bitop(alu_op_e op);
        case (op)
            OP_AND, OP_OR, OP_XOR, OP_COM, OP_SWAP,
            OP_RLC, OP_RRC, OP_RL, OP_RR: return 1'b1;
            default:                      return 1'b0;
        endcase
    endfunction

    // Subtraction is a + ~b + carry-in; carry out then means "no borrow"
    function automatic arith_ctl_t arith_ctl(alu_op_e op);
        arith_ctl_t k;
        k = '{xs: X_OPA, ys: Y_OPB, cs: CI_ZERO};
        case (op)
            OP_ADD:  k = '{xs: X_OPA,  ys: Y_OPB,   cs: CI_ZERO};
            OP_ADDC: k = '{xs: X_OPA,  ys: Y_OPB,   cs: CI_FLAG};
            OP_SUB:  k = '{xs: X_OPA,  ys: Y_NOT_B, cs: CI_ONE};
            OP_SUBB: k = '{xs: X_OPA,  ys: Y_NOT_B, cs: CI_FLAG};
            OP_INC:  k = '{xs: X_OPA,  ys: Y_ZERO,  cs: CI_ONE};
            OP_DEC:  k = '{xs: X_OPA,  ys: Y_ONES,  cs: CI_ZERO};
            OP_NEG:  k = '{xs: X_ZERO, ys: Y_NOT_A, cs: CI_ONE};
            default: k = '{xs: X_OPA,  ys: Y_OPB,   cs: CI_ZERO};
        endcase
        return k;
    endfunction

    function automatic flag_set_t flag_mask(alu_op_e op);
        flag_set_t m;
        m = '0;
        case (op)
            OP_ADD, OP_ADDC, OP_SUB, OP_SUBB,
            OP_INC, OP_DEC:                  m = '{c: 1'b1, dc: 1'b1, z: 1'b1, ov: 1'b1};
            OP_NEG:                          m = '{c: 1'b1, dc: 1'b0, z: 1'b1, ov: 1'b1};
            OP_AND, OP_OR, OP_XOR, OP_COM:   m = '{c: 1'b0, dc: 1'b0, z: 1'b1, ov: 1'b0};
            OP_RLC, OP_RRC:                  m = '{c: 1'b1, dc: 1'b0, z: 1'b0, ov: 1'b0};
            default:                         m = '0;
        endcase
        return m;
    endfunction

endpackage

// File: rtl/alu_addsub.sv
module alu_addsub #(
    parameter int DATA_W = 8
) (
    input  logic [DATA_W-1:0] x_i,
    input  logic [DATA_W-1:0] y_i,
    input  logic              ci_i,
    output logic [DATA_W-1:0] sum_o,
    output logic              co_o,
    output logic              hco_o,
    output logic              ovf_o
);
    localparam int NIB_W = DATA_W / 2;
    localparam int HI_W  = DATA_W - NIB_W;

    logic [NIB_W:0] lo_sum;
    logic [HI_W:0]  hi_sum;

    // Split at the nibble boundary so the half carry is a real wire
    always_comb begin
        lo_sum = {1'b0, x_i[NIB_W-1:0]} + {1'b0, y_i[NIB_W-1:0]}
               + {{NIB_W{1'b0}}, ci_i};
        hi_sum = {1'b0, x_i[DATA_W-1:NIB_W]} + {1'b0, y_i[DATA_W-1:NIB_W]}
               + {{HI_W{1'b0}}, lo_sum[NIB_W]};
    end

    assign sum_o = {hi_sum[HI_W-1:0], lo_sum[NIB_W-1:0]};
    assign co_o  = hi_sum[HI_W];
    assign hco_o = lo_sum[NIB_W];
    // Same-sign inputs with a different-sign sum
    assign ovf_o = (x_i[DATA_W-1] == y_i[DATA_W-1]) &&
                   (sum_o[DATA_W-1] != x_i[DATA_W-1]);

endmodule

// File: rtl/alu_bitops.sv
module alu_bitops
    import alu_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  alu_op_e           op_i,
    input  logic [DATA_W-1:0] a_i,
    input  logic [DATA_W-1:0] b_i,
    input  logic              c_i,
    output logic [DATA_W-1:0] res_o,
    output logic              c_o
);
    localparam int NIB_W = DATA_W / 2;

    always_comb begin
        res_o = '0;
        c_o   = c_i;
        case (op_i)
            OP_AND:  res_o = a_i & b_i;
            OP_OR:   res_o = a_i | b_i;
            OP_XOR:  res_o = a_i ^ b_i;
            OP_COM:  res_o = ~a_i;
            OP_SWAP: res_o = {a_i[NIB_W-1:0], a_i[DATA_W-1:NIB_W]};
            OP_RLC: begin
                res_o = {a_i[DATA_W-2:0], c_i};
                c_o   = a_i[DATA_W-1];
            end
            OP_RRC: begin
                res_o = {c_i, a_i[DATA_W-1:1]};
                c_o   = a_i[0];
            end
            OP_RL:   res_o = {a_i[DATA_W-2:0], a_i[DATA_W-1]};
            OP_RR:   res_o = {a_i[0], a_i[DATA_W-1:1]};
            default: res_o = '0;
        endcase
    end

endmodule

// File: rtl/alu_mult.sv
module alu_mult #(
    parameter int DATA_W    = 8,
    parameter bit SHIFT_ADD = 1'b0
) (
    input  logic [DATA_W-1:0]   a_i,
    input  logic [DATA_W-1:0]   b_i,
    output logic [2*DATA_W-1:0] p_o
);
    localparam int P_W = 2 * DATA_W;

    generate
        if (SHIFT_ADD) begin : g_array
            // Explicit partial-product accumulation
            always_comb begin
                p_o = '0;
                for (int i = 0; i < DATA_W; i++) begin
                    if (b_i[i]) begin
                        p_o = p_o + ({{DATA_W{1'b0}}, a_i} << i);
                    end
                end
            end
        end else begin : g_operator
            assign p_o = P_W'(a_i) * P_W'(b_i);
        end
    endgenerate

endmodule

// File: rtl/alu_core.sv
module alu_core
    import alu_pkg::*;
#(
    parameter int DATA_W    = 8,
    parameter bit SHIFT_ADD = 1'b0
) (
    input  logic [4:0]          op_i,
    input  logic [DATA_W-1:0]   a_i,
    input  logic [DATA_W-1:0]   b_i,
    input  logic                c_i,
    input  logic                dc_i,
    output logic [DATA_W-1:0]   res_o,
    output logic [2*DATA_W-1:0] prod_o,
    output logic                c_o,
    output logic                dc_o,
    output logic                z_o,
    output logic                ov_o,
    output logic                c_we_o,
    output logic                dc_we_o,
    output logic                z_we_o,
    output logic                ov_we_o
);
    localparam logic [DATA_W-1:0] MAX_POS = {1'b0, {(DATA_W-1){1'b1}}};

    alu_op_e    op;
    arith_ctl_t actl;
    flag_set_t  mask;

    logic [DATA_W-1:0]   add_x, add_y, add_sum;
    logic                add_ci, add_co, add_hco, add_ovf;
    logic [DATA_W-1:0]   bit_res;
    logic                bit_c;
    logic [2*DATA_W-1:0] mul_p;

    assign op   = alu_op_e'(op_i);
    assign actl = arith_ctl(op);
    assign mask = flag_mask(op);

    // Operand steering for the shared adder
    always_comb begin
        add_x = (actl.xs == X_ZERO) ? '0 : a_i;
        case (actl.ys)
            Y_OPB:   add_y = b_i;
            Y_NOT_B: add_y = ~b_i;
            Y_ZERO:  add_y = '0;
            Y_ONES:  add_y = '1;
            Y_NOT_A: add_y = ~a_i;
            default: add_y = b_i;
        endcase
        case (actl.cs)
            CI_ZERO: add_ci = 1'b0;
            CI_ONE:  add_ci = 1'b1;
            CI_FLAG: add_ci = c_i;
            default: add_ci = 1'b0;
        endcase
    end

    alu_addsub #(.DATA_W(DATA_W)) u_addsub (
        .x_i  (add_x),
        .y_i  (add_y),
        .ci_i (add_ci),
        .sum_o(add_sum),
        .co_o (add_co),
        .hco_o(add_hco),
        .ovf_o(add_ovf)
    );

    alu_bitops #(.DATA_W(DATA_W)) u_bitops (
        .op_i (op),
        .a_i  (a_i),
        .b_i  (b_i),
        .c_i  (c_i),
        .res_o(bit_res),
        .c_o  (bit_c)
    );

    alu_mult #(.DATA_W(DATA_W), .SHIFT_ADD(SHIFT_ADD)) u_mult (
        .a_i(a_i),
        .b_i(b_i),
        .p_o(mul_p)
    );

    // Result and product selection
    always_comb begin
        prod_o = '0;
        if (is_arith(op)) begin
            res_o = add_sum;
        end else if (is_bitop(op)) begin
            res_o = bit_res;
        end else if (op == OP_MUL) begin
            res_o  = mul_p[DATA_W-1:0];
            prod_o = mul_p;
        end else begin
            res_o = '0;
        end
    end

    // Flag next values, gated by the per-operation mask
    always_comb begin
        c_we_o  = mask.c;
        dc_we_o = mask.dc;
        z_we_o  = mask.z;
        ov_we_o = mask.ov;
        c_o     = c_i;
        dc_o    = dc_i;
        if (mask.c) begin
            c_o = is_arith(op) ? add_co : bit_c;
        end
        if (mask.dc) begin
            dc_o = add_hco;
        end
        z_o  = mask.z && (res_o == '0);
        ov_o = mask.ov && add_ovf;
    end

    // Checks beside the selection logic
    always_comb begin
        AST_ADD_CARRY: assert (!(op == OP_ADD) || (c_o == (a_i > ~b_i)))
            else $error("add carry disagrees with unsigned range"); // R1
        AST_SUB_NO_BORROW: assert (!(op == OP_SUB) || (c_o == (a_i >= b_i)))
            else $error("subtract carry is not the no-borrow compare"); // R2
        AST_INC_OVF: assert (!(op == OP_INC) || (ov_o == (a_i == MAX_POS)))
            else $error("increment overflow wrong"); // R3
        AST_LOGIC_ONLY_Z: assert (!(op inside {OP_AND, OP_OR, OP_XOR, OP_COM})
                                  || (z_we_o && !c_we_o && !dc_we_o && !ov_we_o))
            else $error("logic op wrote a flag other than Z"); // R4
        AST_NEG_DC_KEPT: assert (!(op == OP_NEG) || (!dc_we_o && dc_o == dc_i))
            else $error("negate touched digit carry"); // R5
        AST_MUL_QUIET: assert (!(op == OP_MUL) || ({c_we_o, dc_we_o, z_we_o, ov_we_o} == 4'b0000
                                  && res_o == prod_o[DATA_W-1:0]))
            else $error("multiply wrote flags or result mismatch"); // R9
        AST_UNASSIGNED_IDLE: assert (!(op_i > 5'd16) || ({c_we_o, dc_we_o, z_we_o, ov_we_o} == 4'b0000
                                  && res_o == '0))
            else $error("unassigned code produced activity"); // R11
        AST_PROD_ONLY_MUL: assert ((op == OP_MUL) || (prod_o == '0))
            else $error("product nonzero outside multiply"); // R12
    end

endmodule

// File: tb/tb_alu_core.sv
module tb_alu_core;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [4:0]  op_i = '0;
    logic [7:0]  a_i = '0, b_i = '0;
    logic        c_i = 1'b0, dc_i = 1'b0;
    logic [7:0]  res_o;
    logic [15:0] prod_o;
    logic        c_o, dc_o, z_o, ov_o, c_we_o, dc_we_o, z_we_o, ov_we_o;

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    alu_core dut (
        .op_i(op_i), .a_i(a_i), .b_i(b_i), .c_i(c_i), .dc_i(dc_i),
        .res_o(res_o), .prod_o(prod_o),
        .c_o(c_o), .dc_o(dc_o), .z_o(z_o), .ov_o(ov_o),
        .c_we_o(c_we_o), .dc_we_o(dc_we_o), .z_we_o(z_we_o), .ov_we_o(ov_we_o)
    );

    function automatic int sx(int v);
        return (v >= 128) ? v - 256 : v;
    endfunction

    // Behavioural reference: returns {res, prod, c, dc, z, ov, cwe, dcwe, zwe, ovwe}
    function automatic logic [31:0] model(int op, int a, int b, int c, int dc);
        int r = 0, p = 0, x, y, ci, s, sv;
        int fc = c, fdc = dc, fz = 0, fov = 0;
        int wc = 0, wdc = 0, wz = 0, wov = 0;
        case (op)
            0, 1, 4: begin
                x = a; y = (op == 4) ? 1 : b; ci = (op == 1) ? c : 0;
                s = x + y + ci; r = s & 255;
                fc = (s > 255); fdc = (((x & 15) + (y & 15) + ci) > 15);
                sv = sx(x) + sx(y) + ci; fov = (sv > 127 || sv < -128);
                wc = 1; wdc = 1; wz = 1; wov = 1;
            end
            2, 3, 5, 10: begin
                x = (op == 10) ? 0 : a;
                y = (op == 5) ? 1 : (op == 10) ? a : b;
                ci = (op == 3) ? (1 - c) : 0;
                s = x - y - ci; r = s & 255;
                fc = (s >= 0);
                sv = sx(x) - sx(y) - ci; fov = (sv > 127 || sv < -128);
                wc = 1; wz = 1; wov = 1;
                if (op != 10) begin
                    fdc = (((x & 15) - (y & 15) - ci) >= 0); wdc = 1;
                end
            end
            6:  begin r = a & b; wz = 1; end
            7:  begin r = a | b; wz = 1; end
            8:  begin r = a ^ b; wz = 1; end
            9:  begin r = (~a) & 255; wz = 1; end
            11: r = ((a << 4) | (a >> 4)) & 255;
            12: begin r = ((a << 1) & 255) | c; fc = a >> 7; wc = 1; end
            13: begin r = (c << 7) | (a >> 1); fc = a & 1; wc = 1; end
            14: r = ((a << 1) | (a >> 7)) & 255;
            15: r = (a >> 1) | ((a & 1) << 7);
            16: begin p = a * b; r = p & 255; end
            default: ;
        endcase
        fz = wz ? (r == 0) : 0;
        return {r[7:0], p[15:0], fc[0], fdc[0], fz[0], fov[0],
                wc[0], wdc[0], wz[0], wov[0]};
    endfunction

    function automatic string tag_of(int op);
        case (op)
            0, 1:          return "R1";
            2, 3:          return "R2";
            4, 5:          return "R3";
            6, 7, 8, 9:    return "R4";
            10:            return "R5";
            11:            return "R8";
            12, 13:        return "R6";
            14, 15:        return "R7";
            16:            return "R9";
            default:       return "R11";
        endcase
    endfunction

    task automatic check(int op, int a, int b, int c, int dc, string tag);
        logic [31:0] exp_v, got_v;
        @(negedge clk);
        op_i = op[4:0]; a_i = a[7:0]; b_i = b[7:0]; c_i = c[0]; dc_i = dc[0];
        #1;
        exp_v = model(op, a, b, c, dc);
        got_v = {res_o, prod_o, c_o, dc_o, z_o, ov_o, c_we_o, dc_we_o, z_we_o, ov_we_o};
        n_cmp++;
        if (got_v !== exp_v) begin
            n_bad++;
            $display("FAIL %s op=%0d a=%02h b=%02h c=%0d dc=%0d actual=%08h expected=%08h",
                     tag, op, a, b, c, dc, got_v, exp_v);
        end
    endtask

    initial begin
        repeat (3) @(posedge clk);
        rst = 1'b0;
        // Idle inputs after reset: add of zeros sets only Z
        check(0, 8'h00, 8'h00, 0, 0, "R1");
        check(0, 8'hFF, 8'h01, 0, 0, "R1");   // C, DC, Z
        check(0, 8'h7F, 8'h01, 0, 0, "R1");   // OV, DC
        check(1, 8'hFF, 8'h00, 1, 0, "R1");   // carry-in ripples
        check(1, 8'h0F, 8'h00, 1, 0, "R1");   // DC from carry-in only
        check(2, 8'h05, 8'h05, 0, 0, "R2");   // equal: C=1 Z=1
        check(2, 8'h03, 8'h04, 1, 1, "R2");   // borrow: C=0
        check(2, 8'h80, 8'h01, 0, 0, "R2");   // signed overflow
        check(2, 8'h10, 8'h01, 0, 0, "R2");   // nibble borrow only
        check(3, 8'h05, 8'h05, 0, 0, "R2");   // borrow in gives FF
        check(3, 8'h05, 8'h05, 1, 0, "R2");
        check(4, 8'hFF, 8'h00, 0, 0, "R3");
        check(4, 8'h7F, 8'h00, 0, 0, "R3");
        check(5, 8'h00, 8'h00, 1, 1, "R3");
        check(5, 8'h80, 8'h00, 0, 0, "R3");
        check(6, 8'hF0, 8'h0F, 1, 1, "R4");
        check(9, 8'hFF, 8'h00, 0, 1, "R4");
        check(10, 8'h80, 8'h00, 0, 1, "R5");
        check(10, 8'h00, 8'h00, 0, 0, "R5");
        check(10, 8'h01, 8'h00, 1, 0, "R5");
        check(12, 8'h80, 8'h00, 0, 0, "R6");
        check(13, 8'h01, 8'h00, 1, 0, "R6");
        check(14, 8'h81, 8'h00, 0, 1, "R7");
        check(15, 8'h01, 8'h00, 1, 0, "R7");
        check(11, 8'hA5, 8'h00, 1, 1, "R8");
        check(16, 8'hFF, 8'hFF, 1, 1, "R9");
        check(16, 8'h00, 8'h9C, 0, 0, "R9");
        check(14, 8'h3C, 8'h00, 1, 1, "R10"); // no enables: carries pass through
        check(6, 8'hFF, 8'hFF, 0, 0, "R12");  // product stays zero
        check(20, 8'hFF, 8'hFF, 1, 1, "R11");
        check(31, 8'h12, 8'h34, 0, 1, "R11");
        for (int k = 0; k < 3000; k++) begin
            int op = $urandom_range(0, 31);
            check(op, $urandom_range(0, 255), $urandom_range(0, 255),
                  $urandom_range(0, 1), $urandom_range(0, 1), tag_of(op));
        end
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule